// File: doc/BRIEF.md
# Shared-port memory access mapper with debug bypass

This block sits in front of a memory macro that offers exactly one read port and one write port. Several functional write request paths and several functional read request paths from the core compete for those two ports. A fixed priority picks one write and one read per cycle, and a grant goes back to the winning path.

A run-enable input tells the block whether the core is running or halted. While the core is halted, every functional write is suppressed, so the memory keeps the state it had when the core stopped. While halted, an external debugger can also read or write the memory through the same two ports. No extra port is added for debug.

A debug read takes the read port ahead of any functional read. Its data comes back after the memory's read latency, together with a valid strobe. Debug requests made while the core is running have no effect.

Top module: `mem_dbg_mux`

## Requirements
- R1: After reset, `dbg_rvalid_o` and `rd_valid_o` are 0. With no requests present, `mem_we_o` and `mem_re_o` are 0.
- R2: While running, the write port is given to the lowest-numbered asserting write path. `wr_gnt_o` has that path's bit set, and at most one bit is ever set. `mem_waddr_o` and `mem_wdata_o` carry that path's address and data.
- R3: The read port is given to the lowest-numbered asserting read path. `rd_gnt_o` is one-hot for that path, and `mem_raddr_o` carries that path's address.
- R4: While `run_en_i` is 0, `wr_gnt_o` is 0 and no functional write reaches the memory. A word targeted by a blocked write reads back unchanged.
- R5: While halted, a debug write (`dbg_req_i`=1, `dbg_we_i`=1) drives `mem_we_o`=1 with `dbg_addr_i` and `dbg_wdata_i` on the write port.
- R6: While halted, a debug read (`dbg_req_i`=1, `dbg_we_i`=0) drives `mem_re_o`=1 with `dbg_addr_i`. Exactly RD_LAT cycles later, `dbg_rvalid_o` is 1 for one cycle and `dbg_rdata_o` holds the memory word.
- R7: While running, debug requests are ignored: they produce no memory access and no `dbg_rvalid_o`, and they leave the memory contents unchanged.
- R8: While halted, a functional read is granted only in a cycle with no debug read. When a debug read is present, `rd_gnt_o` is 0.
- R9: A granted functional read returns after RD_LAT cycles. `rd_valid_o` then shows the granted path's bit and `rd_data_o` holds the word. `rd_valid_o` and `dbg_rvalid_o` are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | 1: core running; 0: core halted (debug mode) |
| wr_req_i | input | NW | Functional write requests |
| wr_addr_i | input | NW x AW | Write address per path |
| wr_data_i | input | NW x DW | Write data per path |
| wr_gnt_o | output | NW | Write grant, one-hot or zero |
| rd_req_i | input | NR | Functional read requests |
| rd_addr_i | input | NR x AW | Read address per path |
| rd_gnt_o | output | NR | Read grant, one-hot or zero |
| rd_valid_o | output | NR | Functional read data valid, one bit per path |
| rd_data_o | output | DW | Functional read data |
| dbg_req_i | input | 1 | Debug access request |
| dbg_we_i | input | 1 | 1: debug write; 0: debug read |
| dbg_addr_i | input | AW | Debug address |
| dbg_wdata_i | input | DW | Debug write data |
| dbg_rvalid_o | output | 1 | Debug read data valid |
| dbg_rdata_o | output | DW | Debug read data |
| mem_we_o | output | 1 | Memory write enable |
| mem_waddr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| mem_re_o | output | 1 | Memory read enable |
| mem_raddr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data, RD_LAT cycles after `mem_re_o` |

## Verification
The hardest case to reach from the ports is a debug read and a functional read contending in the same halted cycle, with the two returns landing back to back in the read pipeline. The stimulus holds the core, drives both requests together, then drives a second debug read and a lone functional read on the following cycles. The expected sources and words are queued in issue order and checked against each return.

Suppressed writes leave no trace at the write port, so their effect is checked by reading the target word back later through a debug read. Debug writes issued while running are checked the same way, through a later functional read.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FUNC = 2'd1,
    SRC_DBG  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/mpa_prio_arb.sv
module mpa_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest set bit wins
  assign gnt_o = req_i & (~req_i + N'(1));
endmodule

// File: rtl/mpa_rd_track.sv
module mpa_rd_track
  import mpa_pkg::*;
#(
  parameter int LAT = 2,
  parameter int NR  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  rd_src_e       src_i,
  input  logic [NR-1:0] gnt_i,
  output rd_src_e       src_o,
  output logic [NR-1:0] gnt_o
);
  generate
    if (LAT == 0) begin : g_comb
      assign src_o = src_i;
      assign gnt_o = gnt_i;
    end else begin : g_pipe
      rd_src_e       src_q [LAT];
      logic [NR-1:0] gnt_q [LAT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < LAT; i++) begin
            src_q[i] <= SRC_NONE;
            gnt_q[i] <= '0;
          end
        end else begin
          src_q[0] <= src_i;
          gnt_q[0] <= gnt_i;
          for (int i = 1; i < LAT; i++) begin
            src_q[i] <= src_q[i-1];
            gnt_q[i] <= gnt_q[i-1];
          end
        end
      end
      assign src_o = src_q[LAT-1];
      assign gnt_o = gnt_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/mem_dbg_mux.sv
module mem_dbg_mux
  import mpa_pkg::*;
#(
  parameter int NW     = 3,
  parameter int NR     = 2,
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_en_i,
  input  logic [NW-1:0]          wr_req_i,
  input  logic [NW-1:0][AW-1:0]  wr_addr_i,
  input  logic [NW-1:0][DW-1:0]  wr_data_i,
  output logic [NW-1:0]          wr_gnt_o,
  input  logic [NR-1:0]          rd_req_i,
  input  logic [NR-1:0][AW-1:0]  rd_addr_i,
  output logic [NR-1:0]          rd_gnt_o,
  output logic [NR-1:0]          rd_valid_o,
  output logic [DW-1:0]          rd_data_o,
  input  logic                   dbg_req_i,
  input  logic                   dbg_we_i,
  input  logic [AW-1:0]          dbg_addr_i,
  input  logic [DW-1:0]          dbg_wdata_i,
  output logic                   dbg_rvalid_o,
  output logic [DW-1:0]          dbg_rdata_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_waddr_o,
  output logic [DW-1:0]          mem_wdata_o,
  output logic                   mem_re_o,
  output logic [AW-1:0]          mem_raddr_o,
  input  logic [DW-1:0]          mem_rdata_i
);
  logic          halted, dbg_wr, dbg_rd;
  logic [NW-1:0] wreq_q, wgnt;
  logic [NR-1:0] rreq_q, rgnt;
  logic [AW-1:0] f_waddr, f_raddr;
  logic [DW-1:0] f_wdata;
  rd_src_e       iss_src, ret_src;
  logic [NR-1:0] ret_gnt;

  assign halted = ~run_en_i;
  assign dbg_wr = halted & dbg_req_i & dbg_we_i;
  assign dbg_rd = halted & dbg_req_i & ~dbg_we_i;

  // functional writes masked by hold; functional reads yield to debug read
  assign wreq_q = wr_req_i & {NW{run_en_i}};
  assign rreq_q = rd_req_i & {NR{~dbg_rd}};

  mpa_prio_arb #(.N(NW)) u_warb (.req_i(wreq_q), .gnt_o(wgnt));
  mpa_prio_arb #(.N(NR)) u_rarb (.req_i(rreq_q), .gnt_o(rgnt));

  always_comb begin
    f_waddr = '0;
    f_wdata = '0;
    for (int i = 0; i < NW; i++) begin
      if (wgnt[i]) begin
        f_waddr = f_waddr | wr_addr_i[i];
        f_wdata = f_wdata | wr_data_i[i];
      end
    end
  end

  always_comb begin
    f_raddr = '0;
    for (int i = 0; i < NR; i++) begin
      if (rgnt[i]) f_raddr = f_raddr | rd_addr_i[i];
    end
  end

  assign wr_gnt_o    = wgnt;
  assign rd_gnt_o    = rgnt;
  assign mem_we_o    = dbg_wr | (|wgnt);
  assign mem_waddr_o = dbg_wr ? dbg_addr_i  : f_waddr;
  assign mem_wdata_o = dbg_wr ? dbg_wdata_i : f_wdata;
  assign mem_re_o    = dbg_rd | (|rgnt);
  assign mem_raddr_o = dbg_rd ? dbg_addr_i  : f_raddr;

  always_comb begin
    if (dbg_rd)      iss_src = SRC_DBG;
    else if (|rgnt)  iss_src = SRC_FUNC;
    else             iss_src = SRC_NONE;
  end

  mpa_rd_track #(.LAT(RD_LAT), .NR(NR)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (iss_src),
    .gnt_i  (rgnt),
    .src_o  (ret_src),
    .gnt_o  (ret_gnt)
  );

  assign dbg_rvalid_o = (ret_src == SRC_DBG);
  assign rd_valid_o   = (ret_src == SRC_FUNC) ? ret_gnt : '0;
  assign dbg_rdata_o  = mem_rdata_i;
  assign rd_data_o    = mem_rdata_i;
endmodule

// File: rtl/mem_dbg_mux_chk.sv
module mem_dbg_mux_chk #(
  parameter int NW     = 3,
  parameter int NR     = 2,
  parameter int RD_LAT = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_en_i,
  input logic          dbg_req_i,
  input logic          dbg_we_i,
  input logic [NW-1:0] wr_req_i,
  input logic [NW-1:0] wr_gnt_o,
  input logic [NR-1:0] rd_req_i,
  input logic [NR-1:0] rd_gnt_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [NR-1:0] rd_valid_o,
  input logic          dbg_rvalid_o
);
  logic dbg_iss, exp_last;
  assign dbg_iss = !run_en_i && dbg_req_i && !dbg_we_i;

  generate
    if (RD_LAT == 0) begin : g_l0
      assign exp_last = dbg_iss;
    end else begin : g_ln
      logic [RD_LAT-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else begin
          pipe_q[0] <= dbg_iss;
          for (int i = 1; i < RD_LAT; i++) pipe_q[i] <= pipe_q[i-1];
        end
      end
      assign exp_last = pipe_q[RD_LAT-1];
    end
  endgenerate

  a_r2_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_gnt_o));
  a_r2_wr_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && wr_req_i[0]) |-> wr_gnt_o[0]);
  a_r3_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_gnt_o));
  a_r4_hold_no_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |-> (wr_gnt_o == '0));
  a_r4_hold_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !(dbg_req_i && dbg_we_i)) |-> !mem_we_o);
  a_r7_run_no_dbg_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && wr_req_i == '0) |-> !mem_we_o);
  a_r7_run_no_dbg_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && rd_req_i == '0) |-> !mem_re_o);
  a_r8_dbg_rd_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_iss |-> (rd_gnt_o == '0 && mem_re_o));
  a_r6_dbg_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_rvalid_o == exp_last);
  a_r9_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dbg_rvalid_o, rd_valid_o}));
endmodule

bind mem_dbg_mux mem_dbg_mux_chk #(.NW(NW), .NR(NR), .RD_LAT(RD_LAT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_en_i     (run_en_i),
  .dbg_req_i    (dbg_req_i),
  .dbg_we_i     (dbg_we_i),
  .wr_req_i     (wr_req_i),
  .wr_gnt_o     (wr_gnt_o),
  .rd_req_i     (rd_req_i),
  .rd_gnt_o     (rd_gnt_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .rd_valid_o   (rd_valid_o),
  .dbg_rvalid_o (dbg_rvalid_o)
);

// File: tb/sim_mem_dbg_mux.sv
module sim_mem_dbg_mux;
  localparam int NW = 3, NR = 2, AW = 6, DW = 16, LAT = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                  run_en;
  logic [NW-1:0]         wr_req;
  logic [NW-1:0][AW-1:0] wr_addr;
  logic [NW-1:0][DW-1:0] wr_data;
  logic [NW-1:0]         wr_gnt;
  logic [NR-1:0]         rd_req;
  logic [NR-1:0][AW-1:0] rd_addr;
  logic [NR-1:0]         rd_gnt, rd_valid;
  logic [DW-1:0]         rd_data;
  logic                  dbg_req, dbg_we, dbg_rvalid;
  logic [AW-1:0]         dbg_addr;
  logic [DW-1:0]         dbg_wdata, dbg_rdata;
  logic                  mem_we, mem_re;
  logic [AW-1:0]         mem_waddr, mem_raddr;
  logic [DW-1:0]         mem_wdata, mem_rdata;

  mem_dbg_mux #(.NW(NW), .NR(NR), .AW(AW), .DW(DW), .RD_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_gnt_o(wr_gnt),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_gnt_o(rd_gnt),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .dbg_req_i(dbg_req), .dbg_we_i(dbg_we), .dbg_addr_i(dbg_addr),
    .dbg_wdata_i(dbg_wdata), .dbg_rvalid_o(dbg_rvalid), .dbg_rdata_o(dbg_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return DW'(i * 257) ^ 16'h5a00;
  endfunction

  // behavioural memory, LAT-cycle read
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rpipe [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
      for (int i = 0; i < LAT; i++) rpipe[i] <= '0;
    end else begin
      if (mem_we) mem[mem_waddr] <= mem_wdata;
      if (mem_re) rpipe[0] <= mem[mem_raddr];
      for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
    end
  end
  assign mem_rdata = rpipe[LAT-1];

  typedef struct {
    bit            dbg;
    logic [NR-1:0] path;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t q[$];
  logic [DW-1:0] shadow [DEPTH];

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    run_en = 1'b1; wr_req = '0; wr_addr = '0; wr_data = '0;
    rd_req = '0; rd_addr = '0; dbg_req = 1'b0; dbg_we = 1'b0;
    dbg_addr = '0; dbg_wdata = '0;
  endtask

  task automatic push(bit d, logic [NR-1:0] p, logic [AW-1:0] a, string tag);
    exp_t e;
    e.dbg = d; e.path = p; e.data = shadow[a]; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && (dbg_rvalid || (|rd_valid))) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 R9 unexpected return", {dbg_rvalid, rd_valid}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(dbg_rvalid == e.dbg && rd_valid == e.path, e.tag,
            {dbg_rvalid, rd_valid}, {e.dbg, e.path});
        chk((e.dbg ? dbg_rdata : rd_data) == e.data, e.tag,
            e.dbg ? dbg_rdata : rd_data, e.data);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
    clr();
    repeat (3) @(negedge clk);
    #1;
    chk(dbg_rvalid == 0 && rd_valid == 0, "R1 valids in reset", {dbg_rvalid, rd_valid}, 0);
    chk(mem_we == 0 && mem_re == 0, "R1 ports idle", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(dbg_rvalid == 0 && rd_valid == 0, "R1 valids after reset", {dbg_rvalid, rd_valid}, 0);

    // R2 priority among writes
    @(negedge clk); clr();
    wr_req = 3'b110; wr_addr[0] = 1; wr_addr[1] = 2; wr_addr[2] = 3;
    wr_data[0] = 16'h1000; wr_data[1] = 16'h1001; wr_data[2] = 16'h1002;
    #1;
    chk(wr_gnt == 3'b010, "R2 gnt", wr_gnt, 3'b010);
    chk(mem_we && mem_waddr == 2 && mem_wdata == 16'h1001, "R2 port", {mem_we, mem_waddr, mem_wdata}, {1'b1, 6'd2, 16'h1001});
    shadow[2] = 16'h1001;

    @(negedge clk);
    wr_req = 3'b111; #1;
    chk(wr_gnt == 3'b001, "R2 gnt all", wr_gnt, 3'b001);
    chk(mem_waddr == 1 && mem_wdata == 16'h1000, "R2 port all", {mem_waddr, mem_wdata}, {6'd1, 16'h1000});
    shadow[1] = 16'h1000;

    // R3 priority among reads, R9 returns
    @(negedge clk); clr();
    rd_req = 2'b11; rd_addr[0] = 2; rd_addr[1] = 1; #1;
    chk(rd_gnt == 2'b01 && mem_raddr == 2, "R3 rd gnt", {rd_gnt, mem_raddr}, {2'b01, 6'd2});
    push(0, 2'b01, 2, "R9 path0 return");

    @(negedge clk);
    rd_req = 2'b10; #1;
    chk(rd_gnt == 2'b10 && mem_raddr == 1, "R3 rd gnt path1", {rd_gnt, mem_raddr}, {2'b10, 6'd1});
    push(0, 2'b10, 1, "R9 path1 return");

    // R4 writes blocked while held
    @(negedge clk); clr();
    run_en = 0; wr_req = 3'b111; wr_addr[0] = 5; wr_data[0] = 16'hbeef; #1;
    chk(!mem_we && wr_gnt == 0, "R4 blocked", {mem_we, wr_gnt}, 0);

    // R5 debug write while held
    @(negedge clk); clr();
    run_en = 0; dbg_req = 1; dbg_we = 1; dbg_addr = 7; dbg_wdata = 16'hc0de;
    wr_req = 3'b001; wr_addr[0] = 5; wr_data[0] = 16'hbeef; #1;
    chk(mem_we && mem_waddr == 7 && mem_wdata == 16'hc0de, "R5 dbg write", {mem_we, mem_waddr, mem_wdata}, {1'b1, 6'd7, 16'hc0de});
    chk(wr_gnt == 0, "R4 no gnt during dbg write", wr_gnt, 0);
    shadow[7] = 16'hc0de;

    // R6 R8 debug read beats functional read
    @(negedge clk); clr();
    run_en = 0; dbg_req = 1; dbg_addr = 5; rd_req = 2'b01; rd_addr[0] = 7; #1;
    chk(rd_gnt == 0 && mem_re && mem_raddr == 5, "R8 dbg read wins", {rd_gnt, mem_re, mem_raddr}, {2'b00, 1'b1, 6'd5});
    push(1, 2'b00, 5, "R4 R6 blocked word intact");

    @(negedge clk); clr();
    run_en = 0; dbg_req = 1; dbg_addr = 7; #1;
    chk(mem_re && mem_raddr == 7, "R6 dbg read port", {mem_re, mem_raddr}, {1'b1, 6'd7});
    push(1, 2'b00, 7, "R5 R6 dbg readback");

    @(negedge clk); clr();
    run_en = 0; rd_req = 2'b10; rd_addr[1] = 7; #1;
    chk(rd_gnt == 2'b10 && mem_raddr == 7, "R8 func read while held", {rd_gnt, mem_raddr}, {2'b10, 6'd7});
    push(0, 2'b10, 7, "R8 R9 held func return");

    // R7 debug ignored while running
    @(negedge clk); clr();
    dbg_req = 1; dbg_we = 1; dbg_addr = 9; dbg_wdata = 16'h1111; #1;
    chk(!mem_we, "R7 dbg write ignored", mem_we, 0);

    @(negedge clk); clr();
    dbg_req = 1; dbg_addr = 9; #1;
    chk(!mem_re, "R7 dbg read ignored", mem_re, 0);

    @(negedge clk); clr();
    dbg_req = 1; dbg_addr = 3; rd_req = 2'b01; rd_addr[0] = 9; #1;
    chk(rd_gnt == 2'b01 && mem_raddr == 9, "R7 func read proceeds", {rd_gnt, mem_raddr}, {2'b01, 6'd9});
    push(0, 2'b01, 9, "R7 word untouched");

    @(negedge clk); clr();
    dbg_req = 1; dbg_we = 1; dbg_addr = 11; dbg_wdata = 16'h3333;
    wr_req = 3'b100; wr_addr[2] = 10; wr_data[2] = 16'h2222; #1;
    chk(wr_gnt == 3'b100 && mem_waddr == 10 && mem_wdata == 16'h2222, "R7 R2 func write over dbg",
        {wr_gnt, mem_waddr, mem_wdata}, {3'b100, 6'd10, 16'h2222});
    shadow[10] = 16'h2222;

    @(negedge clk); clr();
    run_en = 0; dbg_req = 1; dbg_addr = 10; #1;
    push(1, 2'b00, 10, "R6 readback after run write");

    @(negedge clk); clr();
    run_en = 0; dbg_req = 1; dbg_addr = 11; #1;
    push(1, 2'b00, 11, "R7 dbg write in run left word");

    @(negedge clk); clr();
    repeat (LAT + 3) @(negedge clk);
    #2;
    chk(q.size() == 0, "R9 all returns seen", q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule